// File: doc/BRIEF.md
# Time-Slot Interchange Switch Core

This block switches byte-wide TDM traffic in time and in space. Each clock cycle is one time slot. In every cycle, one byte arrives from each input highway, and all of them are written into a double-banked data store at the current slot address. A frame sync pulse marks slot 0 and swaps the banks, so one bank fills with the running frame while the other holds the complete previous frame.

A connection store has one entry for every output highway and slot. An entry names a source highway and a source slot. It also carries a valid flag, a latency-mode flag and a test-pattern enable with its pattern byte. In each slot, the output stage reads the entry of every output highway in parallel. Each output highway then gets the idle byte, the pattern byte or the switched sample.

Frame-integrity connections always read the previous frame. Low-latency connections read the running frame when the source slot is already stored, and the previous frame otherwise. Connection changes are written through a side port into a shadow copy. The shadow copy becomes live at the next frame sync.

Top module: `tsi_switch_core`

## Requirements
- R1: During and right after reset, every output highway presents 0xFF and the output slot number is 0.
- R2: A cycle with `fsync_i` high is input slot 0, and each later cycle is the next slot, wrapping after N_SLOT-1. The bytes for output slot s appear one clock edge after the input cycle of slot s, with `out_slot_o` equal to s.
- R3: An output slot whose live entry has the valid flag clear outputs 0xFF, whatever its pattern enable or source fields hold.
- R4: A valid entry with the frame-integrity flag set, and pattern enable clear, outputs the byte that the named source highway carried in the named source slot of the previous frame. This holds for any order of source and output slot.
- R5: A valid entry with the frame-integrity flag clear, and pattern enable clear, outputs the running frame's sample when the source slot number is lower than the output slot number. It outputs the previous frame's sample when the source slot number is equal to or higher than the output slot number.
- R6: A valid entry with the pattern enable set outputs its own pattern byte instead of switched data.
- R7: A connection write made in a cycle with `fsync_i` low changes nothing in the running frame and is live from the next frame sync on. A write made in a frame sync cycle goes live one frame later.
- R8: Any number of output slots, on any output highways, can be connected to the same source at the same time, and each one receives the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, one time slot per cycle |
| rst_ni | input | 1 | Active-low synchronous reset |
| fsync_i | input | 1 | Frame sync; high in the cycle of input slot 0 |
| in_data_i | input | N_HWY*W | Input bytes, highway h at bits [h*W +: W] |
| out_data_o | output | N_HWY*W | Output bytes, highway h at bits [h*W +: W] |
| out_slot_o | output | $clog2(N_SLOT) | Slot number of the bytes on out_data_o |
| cfg_we_i | input | 1 | Connection write strobe |
| cfg_out_hwy_i | input | $clog2(N_HWY) | Output highway of the entry written |
| cfg_out_slot_i | input | $clog2(N_SLOT) | Output slot of the entry written |
| cfg_valid_i | input | 1 | Entry valid flag |
| cfg_frame_int_i | input | 1 | 1: frame-integrity mode, 0: low-latency mode |
| cfg_pattern_en_i | input | 1 | Test-pattern enable |
| cfg_src_hwy_i | input | $clog2(N_HWY) | Source highway |
| cfg_src_slot_i | input | $clog2(N_SLOT) | Source slot |
| cfg_pattern_i | input | W | Pattern byte sent when the pattern enable is set |

## Verification
Each switched byte has one register between the input cycle of its slot and the output. The bench drives a slot on a falling edge and reads the result on the next falling edge, just after the rising edge that captured it. It checks that result before driving the following slot.

The expected value depends on the frame number. The bench keeps frame-tagged sample values, so each result must come from the right frame: the running frame or the previous one. The bench also keeps a shadow and a live copy of the connection table, and swaps them at the falling edge where it raises frame sync. This matches the one-frame delay of writes in R7. A write that is still pending when a result is checked is labelled R7 in that check.

// File: rtl/tsi_pkg.sv
`timescale 1ns/1ps
package tsi_pkg;

    // what an output highway sends in a given slot
    typedef enum logic [1:0] {
        SEL_IDLE     = 2'd0,
        SEL_PATTERN  = 2'd1,
        SEL_SWITCHED = 2'd2
    } sel_e;

endpackage

// File: rtl/tsi_frame_timer.sv
`timescale 1ns/1ps
module tsi_frame_timer #(
    parameter int N_SLOT = 32,
    localparam int SW = $clog2(N_SLOT)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          fsync_i,
    output logic [SW-1:0] slot_o,
    output logic          bank_o
);

    typedef struct packed {
        logic [SW-1:0] slot;
        logic          bank;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        slot_o = fsync_i ? '0 : st_q.slot;
        bank_o = fsync_i ? ~st_q.bank : st_q.bank;
        st_d.slot = (slot_o == SW'(N_SLOT - 1)) ? '0 : slot_o + 1'b1;
        st_d.bank = bank_o;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4 / R5: the banks trade roles exactly at each frame sync
    a_r4_bank_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fsync_i |=> st_q.bank != $past(st_q.bank));
    a_r4_bank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fsync_i |=> $stable(st_q.bank));

endmodule

// File: rtl/tsi_conn_store.sv
`timescale 1ns/1ps
module tsi_conn_store #(
    parameter int N_HWY = 4,
    parameter int N_SLOT = 32,
    parameter int EW = 18,
    localparam int HW = $clog2(N_HWY),
    localparam int SW = $clog2(N_SLOT),
    localparam int NE = N_HWY * N_SLOT
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         start_i,
    input  logic [SW-1:0]                rd_slot_i,
    input  logic                         we_i,
    input  logic [HW-1:0]                wr_hwy_i,
    input  logic [SW-1:0]                wr_slot_i,
    input  logic [EW-1:0]                wr_entry_i,
    output logic [N_HWY-1:0][EW-1:0]     rd_entry_o
);

    typedef struct packed {
        logic [NE-1:0][EW-1:0] shadow;
        logic [NE-1:0][EW-1:0] active;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = st_q.shadow;
        end
        if (we_i && (int'(wr_hwy_i) < N_HWY)) begin
            st_d.shadow[int'(wr_hwy_i) * N_SLOT + int'(wr_slot_i)] = wr_entry_i;
        end
        for (int h = 0; h < N_HWY; h++) begin
            // a new frame already sees the table loaded at its sync
            rd_entry_o[h] = start_i ? st_q.shadow[h * N_SLOT + int'(rd_slot_i)]
                                    : st_q.active[h * N_SLOT + int'(rd_slot_i)];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: the live table changes only at a frame sync, and then to the shadow copy
    a_r7_live_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> $stable(st_q.active));
    a_r7_live_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> st_q.active == $past(st_q.shadow));

endmodule

// File: rtl/tsi_data_store.sv
`timescale 1ns/1ps
module tsi_data_store #(
    parameter int N_HWY = 4,
    parameter int N_SLOT = 32,
    parameter int W = 8,
    localparam int HW = $clog2(N_HWY),
    localparam int SW = $clog2(N_SLOT),
    localparam int NE = N_HWY * N_SLOT
) (
    input  logic                     clk_i,
    input  logic                     wr_bank_i,
    input  logic [SW-1:0]            wr_slot_i,
    input  logic [N_HWY-1:0][W-1:0]  wr_data_i,
    input  logic [N_HWY-1:0]         rd_bank_i,
    input  logic [N_HWY-1:0][HW-1:0] rd_hwy_i,
    input  logic [N_HWY-1:0][SW-1:0] rd_slot_i,
    output logic [N_HWY-1:0][W-1:0]  rd_data_o
);

    logic [1:0][NE-1:0][W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int h = 0; h < N_HWY; h++) begin
            mem_d[wr_bank_i][h * N_SLOT + int'(wr_slot_i)] = wr_data_i[h];
        end
        for (int p = 0; p < N_HWY; p++) begin
            rd_data_o[p] = mem_q[rd_bank_i[p]][int'(rd_hwy_i[p]) * N_SLOT + int'(rd_slot_i[p])];
        end
    end

    // sample storage carries no reset
    always_ff @(posedge clk_i) begin
        mem_q <= mem_d;
    end

endmodule

// File: rtl/tsi_switch_core.sv
`timescale 1ns/1ps
module tsi_switch_core
    import tsi_pkg::*;
#(
    parameter int N_HWY = 4,
    parameter int N_SLOT = 32,
    parameter int W = 8,
    localparam int HW = $clog2(N_HWY),
    localparam int SW = $clog2(N_SLOT)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               fsync_i,
    input  logic [N_HWY*W-1:0] in_data_i,
    output logic [N_HWY*W-1:0] out_data_o,
    output logic [SW-1:0]      out_slot_o,
    input  logic               cfg_we_i,
    input  logic [HW-1:0]      cfg_out_hwy_i,
    input  logic [SW-1:0]      cfg_out_slot_i,
    input  logic               cfg_valid_i,
    input  logic               cfg_frame_int_i,
    input  logic               cfg_pattern_en_i,
    input  logic [HW-1:0]      cfg_src_hwy_i,
    input  logic [SW-1:0]      cfg_src_slot_i,
    input  logic [W-1:0]       cfg_pattern_i
);

    // entry layout, low to high: pattern, source slot, source highway, flags
    localparam int SS_LSB = W;
    localparam int SH_LSB = W + SW;
    localparam int TP_BIT = W + SW + HW;
    localparam int FI_BIT = TP_BIT + 1;
    localparam int V_BIT  = TP_BIT + 2;
    localparam int EW     = TP_BIT + 3;

    typedef struct packed {
        logic [N_HWY-1:0][W-1:0] out;
        logic [SW-1:0]           slot;
    } state_t;

    state_t st_d, st_q;

    logic [SW-1:0]            cur_slot;
    logic                     cur_bank;
    logic [EW-1:0]            wr_entry;
    logic [N_HWY-1:0][EW-1:0] ent;
    logic [N_HWY-1:0]         ent_valid, ent_fi, ent_tp;
    logic [N_HWY-1:0][W-1:0]  ent_pat, ds_data;
    logic [N_HWY-1:0][HW-1:0] rd_hwy;
    logic [N_HWY-1:0][SW-1:0] rd_slot;
    logic [N_HWY-1:0]         rd_bank;
    sel_e                     sel [N_HWY];

    assign wr_entry = {cfg_valid_i, cfg_frame_int_i, cfg_pattern_en_i,
                       cfg_src_hwy_i, cfg_src_slot_i, cfg_pattern_i};

    tsi_frame_timer #(.N_SLOT(N_SLOT)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fsync_i (fsync_i),
        .slot_o  (cur_slot),
        .bank_o  (cur_bank)
    );

    tsi_conn_store #(.N_HWY(N_HWY), .N_SLOT(N_SLOT), .EW(EW)) u_conn (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (fsync_i),
        .rd_slot_i  (cur_slot),
        .we_i       (cfg_we_i),
        .wr_hwy_i   (cfg_out_hwy_i),
        .wr_slot_i  (cfg_out_slot_i),
        .wr_entry_i (wr_entry),
        .rd_entry_o (ent)
    );

    tsi_data_store #(.N_HWY(N_HWY), .N_SLOT(N_SLOT), .W(W)) u_data (
        .clk_i     (clk_i),
        .wr_bank_i (cur_bank),
        .wr_slot_i (cur_slot),
        .wr_data_i (in_data_i),
        .rd_bank_i (rd_bank),
        .rd_hwy_i  (rd_hwy),
        .rd_slot_i (rd_slot),
        .rd_data_o (ds_data)
    );

    always_comb begin
        st_d      = st_q;
        st_d.slot = cur_slot;
        for (int h = 0; h < N_HWY; h++) begin
            ent_valid[h] = ent[h][V_BIT];
            ent_fi[h]    = ent[h][FI_BIT];
            ent_tp[h]    = ent[h][TP_BIT];
            ent_pat[h]   = ent[h][W-1:0];
            rd_hwy[h]    = ent[h][SH_LSB +: HW];
            rd_slot[h]   = ent[h][SS_LSB +: SW];
            // low latency takes the running bank once its source is stored
            rd_bank[h]   = (!ent_fi[h] && (rd_slot[h] < cur_slot)) ? cur_bank : ~cur_bank;
            if (!ent_valid[h]) begin
                sel[h] = SEL_IDLE;
            end else if (ent_tp[h]) begin
                sel[h] = SEL_PATTERN;
            end else begin
                sel[h] = SEL_SWITCHED;
            end
            unique case (sel[h])
                SEL_IDLE:     st_d.out[h] = '1;
                SEL_PATTERN:  st_d.out[h] = ent_pat[h];
                default:      st_d.out[h] = ds_data[h];
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.out  <= '1;
            st_q.slot <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data_o = st_q.out;
    assign out_slot_o = st_q.slot;

    // R2: a frame sync cycle is reported as slot 0 one edge later
    a_r2_sync_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fsync_i |=> out_slot_o == '0);

    for (genvar g = 0; g < N_HWY; g++) begin : g_chk
        // R3: an entry without a connection yields the idle byte
        a_r3_idle_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !ent_valid[g] |=> out_data_o[g*W +: W] == {W{1'b1}});
        // R6: pattern insertion replaces switched data
        a_r6_pattern_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ent_valid[g] && ent_tp[g]) |=> out_data_o[g*W +: W] == $past(ent_pat[g]));
    end

endmodule

// File: tb/tsi_switch_core_bench.sv
`timescale 1ns/1ps
module tsi_switch_core_bench;

    localparam int NH = 4;
    localparam int NS = 32;

    typedef struct packed {
        bit       v;
        bit       fi;
        bit       tp;
        bit [1:0] sh;
        bit [4:0] ss;
        bit [7:0] pat;
    } ent_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic [31:0] in_data = '0;
    logic [31:0] out_data;
    logic [4:0]  out_slot;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_out_hwy = '0;
    logic [4:0]  cfg_out_slot = '0;
    logic        cfg_valid = 1'b0;
    logic        cfg_fi = 1'b0;
    logic        cfg_tp = 1'b0;
    logic [1:0]  cfg_src_hwy = '0;
    logic [4:0]  cfg_src_slot = '0;
    logic [7:0]  cfg_pat = '0;

    int n_chk = 0;
    int n_fail = 0;
    int fr = 0;

    ent_t  shadow [NH][NS];
    ent_t  live   [NH][NS];
    ent_t  wq_e   [128];
    int    wq_h   [128];
    int    wq_s   [128];
    int    wq_n = 0;
    int    wq_rd = 0;
    string ovr    [NH];

    bit          pend = 1'b0;
    logic [7:0]  pend_exp [NH];
    string       pend_tag [NH];
    logic [4:0]  pend_slot;

    always #4 clk = ~clk;

    tsi_switch_core u_tsi_switch_core (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .fsync_i          (fsync),
        .in_data_i        (in_data),
        .out_data_o       (out_data),
        .out_slot_o       (out_slot),
        .cfg_we_i         (cfg_we),
        .cfg_out_hwy_i    (cfg_out_hwy),
        .cfg_out_slot_i   (cfg_out_slot),
        .cfg_valid_i      (cfg_valid),
        .cfg_frame_int_i  (cfg_fi),
        .cfg_pattern_en_i (cfg_tp),
        .cfg_src_hwy_i    (cfg_src_hwy),
        .cfg_src_slot_i   (cfg_src_slot),
        .cfg_pattern_i    (cfg_pat)
    );

    function automatic logic [7:0] sample(int f, int h, int s);
        return 8'(((f & 1) << 7) | (h << 5) | s);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic queue_w(int h, int s, bit v, bit fi, bit tp, int sh, int ss, int pat);
        ent_t e;
        e.v = v; e.fi = fi; e.tp = tp;
        e.sh = 2'(sh); e.ss = 5'(ss); e.pat = 8'(pat);
        wq_e[wq_n] = e; wq_h[wq_n] = h; wq_s[wq_n] = s;
        wq_n++;
    endtask

    task automatic check_pending();
        if (pend) begin
            for (int h = 0; h < NH; h++) begin
                chk(32'(out_data[h*8 +: 8]), 32'(pend_exp[h]), pend_tag[h]);
            end
            chk(32'(out_slot), 32'(pend_slot), "R2 out_slot");
        end
        pend = 1'b0;
    endtask

    task automatic run_frame(int f);
        for (int s = 0; s < NS; s++) begin
            @(negedge clk);
            check_pending();
            if (s == 0) begin
                for (int h = 0; h < NH; h++)
                    for (int k = 0; k < NS; k++) live[h][k] = shadow[h][k];
            end
            fsync = (s == 0);
            for (int h = 0; h < NH; h++) in_data[h*8 +: 8] = sample(f, h, s);
            for (int h = 0; h < NH; h++) begin
                ent_t e;
                e = live[h][s];
                if (!e.v) begin
                    pend_exp[h] = 8'hFF; pend_tag[h] = "R3 idle";
                end else if (e.tp) begin
                    pend_exp[h] = e.pat; pend_tag[h] = "R6 pattern";
                end else if (e.fi) begin
                    pend_exp[h] = sample(f - 1, e.sh, e.ss); pend_tag[h] = "R4 frame integrity";
                end else begin
                    pend_exp[h] = (int'(e.ss) < s) ? sample(f, e.sh, e.ss) : sample(f - 1, e.sh, e.ss);
                    pend_tag[h] = "R5 low latency";
                end
                if (e.v && !e.tp && ovr[h] != "") pend_tag[h] = ovr[h];
                if (shadow[h][s] != e) pend_tag[h] = {"R7 pending write, ", pend_tag[h]};
            end
            pend_slot = 5'(s);
            pend = 1'b1;
            if (wq_rd < wq_n) begin
                ent_t w;
                w = wq_e[wq_rd];
                shadow[wq_h[wq_rd]][wq_s[wq_rd]] = w;
                cfg_we = 1'b1;
                cfg_out_hwy = 2'(wq_h[wq_rd]); cfg_out_slot = 5'(wq_s[wq_rd]);
                cfg_valid = w.v; cfg_fi = w.fi; cfg_tp = w.tp;
                cfg_src_hwy = w.sh; cfg_src_slot = w.ss; cfg_pat = w.pat;
                wq_rd++;
            end else begin
                cfg_we = 1'b0;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_data, 32'hFFFF_FFFF, "R1 reset data");
        chk(32'(out_slot), 0, "R1 reset slot");
        rst_n = 1'b1;
        chk(out_data, 32'hFFFF_FFFF, "R1 data after release");
    endtask

    task automatic t_frame_integrity();
        // R4: reversed slot order, sources spread over all highways
        for (int s = 0; s < NS; s++) queue_w(0, s, 1, 1, 0, s % 4, NS - 1 - s, 0);
        run_frame(fr++);
        run_frame(fr++);
    endtask

    task automatic t_low_latency();
        // R5: mix of sources before, at and after the output slot
        for (int s = 0; s < NS; s++) queue_w(1, s, 1, 0, 0, (s + 1) % 4, (s * 7) % NS, 0);
        run_frame(fr++);
        run_frame(fr++);
    endtask

    task automatic t_pattern();
        // R6 and R3: pattern, pattern with no valid flag, plain connection
        for (int s = 0; s < NS; s++) begin
            if (s % 3 == 0)      queue_w(2, s, 1, 0, 1, 1, s, 8'hA0 ^ s);
            else if (s % 3 == 1) queue_w(2, s, 0, 1, 1, 2, s, 8'h3C);
            else                 queue_w(2, s, 1, 1, 0, 3, s, 0);
        end
        run_frame(fr++);
        run_frame(fr++);
    endtask

    task automatic t_broadcast_reconfig();
        // R8: one source feeds a whole highway plus an existing slot
        ovr[3] = "R8 broadcast";
        for (int s = 0; s < NS; s++) queue_w(3, s, 1, 0, 0, 2, 5, 0);
        // R7: changes to live entries must wait for the next frame
        queue_w(0, 3, 0, 1, 0, 0, 0, 0);
        queue_w(1, 10, 1, 0, 1, 0, 0, 8'h5A);
        run_frame(fr++);
        run_frame(fr++);
        run_frame(fr++);
    endtask

    initial begin
        for (int h = 0; h < NH; h++) begin
            ovr[h] = "";
            for (int k = 0; k < NS; k++) begin
                shadow[h][k] = '0;
                live[h][k] = '0;
            end
        end
        t_reset();
        t_frame_integrity();
        t_low_latency();
        t_pattern();
        t_broadcast_reconfig();
        @(negedge clk);
        check_pending();
        fsync = 1'b0;
        cfg_we = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule